// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the decision core of an eight-input interrupt controller. It keeps three registers: the pending requests, the in-service bits and a rotation offset. Each cycle it works out which unmasked pending request has the highest priority. Priority is counted from a base pin given by the rotation offset. The block raises its interrupt line only when that request outranks every pin currently in service.

When the processor acknowledges, the block does four things:
- It latches a vector made from a programmed base and the winning pin.
- It marks the winning pin in service.
- It clears the pending bit, but only if the pin is edge-triggered.
- With automatic end-of-interrupt enabled, it skips the in-service marking and may move the rotation base.

A non-specific end-of-interrupt strobe retires the highest-priority in-service pin. Programming of the mask, trigger and mode registers is done outside; those values arrive here as plain inputs.

Top module: `irq_rank_resolver`

## Requirements
- R1: While reset is asserted, the pending, in-service and offset registers read zero, `int_o` is low and `vec_o` is zero.
- R2: Priority level p belongs to pin (p + offset) mod 8, and level 0 ranks highest. The candidates are pending AND NOT mask. `int_o` is high in the cycle after a state in which the best candidate's level is strictly smaller than the best in-service level; an empty set has level 8.
- R3: When `nested_i` and `primary_i` are both high, in-service bit 2 is left out of the in-service level. It stays out of the interrupt decision and out of the acknowledge decision.
- R4: An acknowledge (`ack_i` high at a clock edge) with a winning candidate and auto-EOI off sets that pin's in-service bit.
- R5: With `auto_eoi_i` high, an acknowledge leaves the in-service register unchanged. If `rot_aeoi_i` is also high, the offset becomes (pin + 1) mod 8.
- R6: An acknowledge with no winning candidate is spurious. It returns pin 7 and changes no pending, in-service or offset bit.
- R7: On every acknowledge, `vec_o` takes base_i*8 + pin at that clock edge. At all other times it holds its value.
- R8: An `eoi_i` strobe clears the in-service bit of the highest-priority in-service pin, counted with the current offset. It does nothing if no bit is in service. It is applied before a same-cycle acknowledge sets a bit.
- R9: Bits of `pend_set_i` set the matching pending bits at the clock edge. An acknowledge clears the winner's pending bit only when its `level_i` bit is 0 (edge-triggered); a 1 (level-triggered) keeps it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pend_set_i | input | 8 | Request bits to set in the pending register |
| mask_i | input | 8 | 1 masks the pin |
| level_i | input | 8 | 1 level-triggered, 0 edge-triggered |
| base_i | input | 5 | Upper five vector bits |
| nested_i | input | 1 | Special fully nested mode |
| primary_i | input | 1 | This controller is the primary (bit 2 is the cascade input) |
| auto_eoi_i | input | 1 | Automatic end-of-interrupt on acknowledge |
| rot_aeoi_i | input | 1 | Rotate the offset on automatic end-of-interrupt |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| eoi_i | input | 1 | Non-specific end-of-interrupt strobe |
| int_o | output | 1 | Registered interrupt request |
| vec_o | output | 8 | Vector latched at acknowledge |
| pend_o | output | 8 | Pending register |
| isr_o | output | 8 | In-service register |
| off_o | output | 3 | Rotation offset |

## Verification
The bench goes after the cases where the rotation base wraps past pin 7. A resolver that forgets the modulo would pick the wrong winner and put a wrong pin in the vector.

It checks that a candidate of the same level as an in-service pin does not interrupt. An off-by-one in the comparison would raise `int_o` there. It also checks the cascade pin under nested mode, where a design that does not exclude bit 2 would hold back a lower-ranked request.

Spurious acknowledges, level-triggered pins under acknowledge, and same-cycle end-of-interrupt with acknowledge round out the list. A wrong design would clear state it must keep, or return the wrong pin in the vector.

// File: rtl/irq_rank_resolver.sv
module irq_rank_resolver #(
  parameter int NPIN    = 8,
  parameter int VW      = 8,
  parameter int CASCADE = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPIN-1:0]             pend_set_i,
  input  logic [NPIN-1:0]             mask_i,
  input  logic [NPIN-1:0]             level_i,
  input  logic [VW-$clog2(NPIN)-1:0]  base_i,
  input  logic                        nested_i,
  input  logic                        primary_i,
  input  logic                        auto_eoi_i,
  input  logic                        rot_aeoi_i,
  input  logic                        ack_i,
  input  logic                        eoi_i,
  output logic                        int_o,
  output logic [VW-1:0]               vec_o,
  output logic [NPIN-1:0]             pend_o,
  output logic [NPIN-1:0]             isr_o,
  output logic [$clog2(NPIN)-1:0]     off_o
);
  localparam int LW = $clog2(NPIN);
  localparam logic [LW:0] NONE = LW'(0) | (LW+1)'(NPIN);
  localparam logic [NPIN-1:0] CASC_BIT = NPIN'(1) << CASCADE;

  function automatic logic [LW:0] best_level(input logic [NPIN-1:0] v, input logic [LW-1:0] off);
    logic [LW:0] lvl;
    lvl = NONE;
    for (int p = NPIN - 1; p >= 0; p--) begin
      if (v[LW'(p) + off]) lvl = (LW+1)'(p);
    end
    return lvl;
  endfunction

  logic [NPIN-1:0] pend_q, isr_q, cand, isr_eff;
  logic [LW-1:0]   off_q, pin, eoi_pin;
  logic [LW:0]     cand_lvl, isr_lvl, eoi_lvl;
  logic            hit, int_q;
  logic [VW-1:0]   vec_q;

  assign cand     = pend_q & ~mask_i;
  assign isr_eff  = isr_q & ~((nested_i && primary_i) ? CASC_BIT : '0);
  assign cand_lvl = best_level(cand, off_q);
  assign isr_lvl  = best_level(isr_eff, off_q);
  assign eoi_lvl  = best_level(isr_q, off_q);
  assign hit      = cand_lvl < isr_lvl;
  assign pin      = cand_lvl[LW-1:0] + off_q;
  assign eoi_pin  = eoi_lvl[LW-1:0] + off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      isr_q  <= '0;
      off_q  <= '0;
      int_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      logic [NPIN-1:0] pend_d, isr_d;
      pend_d = pend_q;
      isr_d  = isr_q;
      if (eoi_i && eoi_lvl != NONE) isr_d[eoi_pin] = 1'b0;
      if (ack_i && hit) begin
        if (!level_i[pin]) pend_d[pin] = 1'b0;
        if (!auto_eoi_i) isr_d[pin] = 1'b1;
        else if (rot_aeoi_i) off_q <= pin + LW'(1);
      end
      if (ack_i) vec_q <= {base_i, hit ? pin : LW'(NPIN - 1)};
      pend_q <= pend_d | pend_set_i;
      isr_q  <= isr_d;
      int_q  <= hit;
    end
  end

  assign int_o  = int_q;
  assign vec_o  = vec_q;
  assign pend_o = pend_q;
  assign isr_o  = isr_q;
  assign off_o  = off_q;

  assert_int_needs_cand_R2: assert property (@(posedge clk) disable iff (!rst_n)
    int_o |-> $past(|(pend_q & ~mask_i)));
  assert_isr_mark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && hit && !auto_eoi_i) |=> isr_o[$past(pin)]);
  assert_aeoi_no_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && auto_eoi_i) |=> $countones(isr_o) <= $countones($past(isr_o)));
  assert_spurious_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !hit) |=> vec_o[LW-1:0] == LW'(NPIN - 1));
  assert_vec_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> $stable(vec_o));
  assert_pend_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_set_i) |=> (pend_o & $past(pend_set_i)) == $past(pend_set_i));
endmodule

// File: tb/irq_rank_resolver_bench.sv
module irq_rank_resolver_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] pend_set_i = '0, mask_i = '0, level_i = '0;
  logic [4:0] base_i = 5'h0A;
  logic nested_i = 0, primary_i = 0, auto_eoi_i = 0, rot_aeoi_i = 0, ack_i = 0, eoi_i = 0;
  logic int_o;
  logic [7:0] vec_o, pend_o, isr_o;
  logic [2:0] off_o;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  irq_rank_resolver u_irq_rank_resolver (.*);

  int m_pend, m_isr, m_off, m_int, m_vec;

  function automatic int lvl_of(int v, int off);
    for (int p = 0; p < 8; p++) if ((v >> ((p + off) % 8)) & 1) return p;
    return 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_isr = 0; m_off = 0; m_int = 0; m_vec = 0;
    end else begin
      int c, ie, cl, il, win, p, el;
      c  = m_pend & ~int'(mask_i) & 255;
      ie = (nested_i && primary_i) ? (m_isr & ~4) : m_isr;
      cl = lvl_of(c, m_off);
      il = lvl_of(ie, m_off);
      win = cl < il;
      p  = (cl + m_off) % 8;
      m_int = win;
      if (eoi_i) begin
        el = lvl_of(m_isr, m_off);
        if (el < 8) m_isr = m_isr & ~(1 << ((el + m_off) % 8));
      end
      if (ack_i) begin
        if (win) begin
          if (!level_i[p]) m_pend = m_pend & ~(1 << p);
          if (!auto_eoi_i) m_isr = m_isr | (1 << p);
          else if (rot_aeoi_i) m_off = (p + 1) % 8;
          m_vec = int'(base_i) * 8 + p;
        end else m_vec = int'(base_i) * 8 + 7;
      end
      m_pend = m_pend | int'(pend_set_i);
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(int'(int_o), m_int, "R2 int_o");
    chk(int'(vec_o), m_vec, "R7 vec_o");
    chk(int'(pend_o), m_pend, "R9 pend_o");
    chk(int'(isr_o), m_isr, "R4 isr_o");
    chk(int'(off_o), m_off, "R5 off_o");
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set(input logic [7:0] b);
    pend_set_i = b; step(1); pend_set_i = '0;
  endtask

  task automatic pulse_ack;
    ack_i = 1; step(1); ack_i = 0;
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(2);
    chk(int'(int_o), 0, "R1 reset int_o");
    chk(int'(vec_o), 0, "R1 reset vec_o");
    chk(int'({pend_o, isr_o, 5'd0, off_o}), 0, "R1 reset state");
    rst_n = 1; step(1);

    pulse_set(8'h04); pulse_ack(); step(1);
    chk(int'(isr_o), 8'h04, "R4 pin 2 in service");
    pulse_set(8'h08); step(2);
    chk(int'(int_o), 0, "R2 lower rank held off");
    nested_i = 1; primary_i = 1; step(2);
    chk(int'(int_o), 1, "R3 cascade bit ignored");
    nested_i = 0; primary_i = 0;
    eoi_i = 1; step(1); eoi_i = 0;
    pulse_ack(); eoi_i = 1; step(1); eoi_i = 0; step(1);

    mask_i = 8'hFF; pulse_ack(); step(1);
    chk(int'(vec_o), 8'h57, "R6 spurious vector");
    chk(int'(isr_o), 0, "R6 no in-service change");
    mask_i = 8'h00;

    pulse_set(8'h20); pulse_ack(); pulse_set(8'h02); pulse_ack(); step(1);
    chk(int'(isr_o), 8'h22, "R8 setup");
    eoi_i = 1; step(1); eoi_i = 0;
    chk(int'(isr_o), 8'h20, "R8 highest in-service retired");
    eoi_i = 1; step(1); eoi_i = 0;

    auto_eoi_i = 1; rot_aeoi_i = 1;
    pulse_set(8'h10); pulse_ack(); step(1);
    chk(int'(off_o), 5, "R5 rotate after auto-EOI");
    chk(int'(isr_o), 0, "R5 no in-service mark");
    pulse_set(8'h81); pulse_ack(); step(1);
    chk(int'(vec_o[2:0]), 7, "R2 wrapped order picks pin 7");
    level_i = 8'h01; pulse_ack(); step(1);
    chk(int'(pend_o), 8'h01, "R9 level pin stays pending");
    auto_eoi_i = 0; rot_aeoi_i = 0; level_i = 0;

    for (int i = 0; i < 6000; i++) begin
      if (i % 50 == 0) begin
        {nested_i, primary_i, auto_eoi_i, rot_aeoi_i} = 4'($urandom);
        level_i = 8'($urandom) & 8'($urandom);
        base_i = 5'($urandom);
      end
      if (i % 13 == 0) mask_i = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
      pend_set_i = ($urandom % 4 == 0) ? 8'(1 << ($urandom % 8)) : 8'h00;
      ack_i = ($urandom % 4 == 0);
      eoi_i = ($urandom % 6 == 0);
      if (i % 997 == 500) begin rst_n = 0; step(1); rst_n = 1; end
      step(1);
    end
    ack_i = 0; eoi_i = 0; pend_set_i = 0;
    step(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule